// File: doc/BRIEF.md
# 64-bit Bit-Manipulation Unit

This block performs one bit-level operation per accepted request on 64-bit unsigned words and returns the result one clock later. A 4-bit opcode selects the operation. The operations are:

- bitwise inversion;
- a bitwise AND, OR or XOR reduction over any subset of four operand ports, with an optional final inversion;
- a logical shift whose signed count gives the direction;
- a population count;
- a single-bit test;
- a single-bit force to a given value.

A request is presented with `in_valid` high. The opcode, the operands, the per-port enable mask, the signed count/index and the bit value are sampled on that clock edge. `result` and `out_valid` follow on the next edge. Single-operand operations read operand port 0. The one-bit value input is treated as a zero-extended word, and the one-bit answers are returned zero-extended to 64 bits.

Top module: `bitmanip_unit`

## Requirements
- R1: Opcode 0 returns the inversion of all 64 bits of operand 0. An operand of 0 gives all ones, and an operand of 1 gives all ones except bit 0.
- R2: Opcodes 1, 2 and 3 return the bitwise AND, OR and XOR, respectively, of every operand port whose bit in `opnd_en` is set. Bit i of `opnd_en` enables port i, and port i occupies bits [64*i+63 : 64*i] of `opnd`.
- R3: Opcodes 4, 5 and 6 return the bitwise inversion of the results that opcodes 1, 2 and 3 would give for the same inputs.
- R4: When `opnd_en` is zero, the reduction takes its identity value before any inversion: all ones for AND, and zero for OR and XOR.
- R5: Opcode 7 shifts operand 0 left by `amt` places when `amt` is positive, and right by -`amt` places when it is negative, filling with zeros. `amt` is two's complement, and `amt` = 0 returns the operand unchanged.
- R6: A shift with a magnitude of 64 or more returns zero.
- R7: Opcode 8 returns the number of set bits in operand 0, from 0 to 64, as an unsigned word.
- R8: Opcode 9 returns 1 when bit `amt` of operand 0 is set, and 0 otherwise. Bits 63..1 of the result are always zero. An `amt` outside 0..63 returns 0.
- R9: Opcode 10 returns operand 0 with bit `amt` forced to `bit_val` and all other bits unchanged. An `amt` outside 0..63 returns operand 0 unchanged.
- R10: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high, and `result` is updated on that same edge. While `in_valid` is low, `result` holds its value. Reset clears `out_valid` and `result`.
- R11: Opcodes 11 to 15 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Request strobe; the inputs below are sampled when high |
| opcode | input | 4 | Operation select |
| opnd | input | 256 | Four 64-bit operand ports, port 0 in the low bits |
| opnd_en | input | 4 | Per-port enable for the reductions |
| amt | input | 8 | Signed shift count, or bit index |
| bit_val | input | 1 | Value written by the bit-force operation |
| out_valid | output | 1 | Result valid, one cycle after `in_valid` |
| result | output | 64 | Registered result |

## Verification
The block holds no state beyond the output register, so any fault appears in the first `result` after the faulty request. Such a fault could be a wrong identity seed, a swapped shift direction, an off-by-one range limit or a missing final inversion. Corner requests sit at the edges of each range: counts of ±63, ±64, -128 and 127, indices of -1, 63 and 64, an all-zero enable mask, and operands of all zeros and all ones. A fault in the valid pipeline or the hold path shows in the idle cycle that follows every request.

// File: rtl/bm_pkg.sv
package bm_pkg;
  typedef enum logic [3:0] {
    OP_INV    = 4'd0,
    OP_AND    = 4'd1,
    OP_OR     = 4'd2,
    OP_XOR    = 4'd3,
    OP_NAND   = 4'd4,
    OP_NOR    = 4'd5,
    OP_XNOR   = 4'd6,
    OP_SHIFT  = 4'd7,
    OP_POPCNT = 4'd8,
    OP_TEST   = 4'd9,
    OP_FORCE  = 4'd10
  } bm_op_e;

  typedef enum logic [1:0] {
    RED_AND = 2'd0,
    RED_OR  = 2'd1,
    RED_XOR = 2'd2
  } bm_red_e;
endpackage

// File: rtl/bm_reduce.sv
module bm_reduce
  import bm_pkg::*;
#(
  parameter int W    = 64,
  parameter int NOPS = 4
) (
  input  logic [NOPS*W-1:0] opnd,
  input  logic [NOPS-1:0]   en,
  input  bm_red_e           kind,
  input  logic              invert,
  output logic [W-1:0]      y
);
  logic [W-1:0] acc [NOPS+1];

  // seed with the identity of the selected reduction
  assign acc[0] = (kind == RED_AND) ? {W{1'b1}} : {W{1'b0}};

  for (genvar i = 0; i < NOPS; i++) begin : g_stage
    logic [W-1:0] term;
    assign term = opnd[i*W +: W];
    always_comb begin
      acc[i+1] = acc[i];
      if (en[i]) begin
        unique case (kind)
          RED_AND: acc[i+1] = acc[i] & term;
          RED_OR:  acc[i+1] = acc[i] | term;
          default: acc[i+1] = acc[i] ^ term;
        endcase
      end
    end
  end

  assign y = invert ? ~acc[NOPS] : acc[NOPS];
endmodule

// File: rtl/bm_shift.sv
module bm_shift #(
  parameter int W  = 64,
  parameter int CW = 8
) (
  input  logic [W-1:0]         a,
  input  logic signed [CW-1:0] amt,
  output logic [W-1:0]         y
);
  localparam int MW = CW + 1;

  logic          go_right;
  logic [MW-1:0] mag;

  always_comb begin
    go_right = amt[CW-1];
    mag      = go_right ? (~{amt[CW-1], amt} + 1'b1) : {1'b0, amt};
    if (int'(mag) >= W)   y = '0;
    else if (go_right)    y = a >> mag;
    else                  y = a << mag;
  end
endmodule

// File: rtl/bm_popcount.sv
module bm_popcount #(
  parameter int W = 64,
  localparam int CNTW = $clog2(W + 1)
) (
  input  logic [W-1:0]    a,
  output logic [CNTW-1:0] cnt
);
  always_comb begin
    cnt = '0;
    for (int i = 0; i < W; i++) begin
      cnt = cnt + CNTW'(a[i]);
    end
  end
endmodule

// File: rtl/bm_bitfield.sv
module bm_bitfield #(
  parameter int W  = 64,
  parameter int CW = 8
) (
  input  logic [W-1:0]         a,
  input  logic signed [CW-1:0] idx,
  input  logic                 val,
  output logic [W-1:0]         test_y,
  output logic [W-1:0]         force_y
);
  localparam int IDXW = $clog2(W);

  logic         in_range;
  logic [W-1:0] mask;

  always_comb begin
    in_range = (int'(idx) >= 0) && (int'(idx) < W);
    mask     = in_range ? (W'(1) << idx[IDXW-1:0]) : '0;
    test_y   = W'(|(a & mask));
    force_y  = val ? (a | mask) : (a & ~mask);
  end
endmodule

// File: rtl/bitmanip_unit.sv
module bitmanip_unit
  import bm_pkg::*;
#(
  parameter int W    = 64,
  parameter int NOPS = 4,
  parameter int CW   = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [3:0]           opcode,
  input  logic [NOPS*W-1:0]    opnd,
  input  logic [NOPS-1:0]      opnd_en,
  input  logic signed [CW-1:0] amt,
  input  logic                 bit_val,
  output logic                 out_valid,
  output logic [W-1:0]         result
);
  localparam int CNTW = $clog2(W + 1);

  // reset: asserted asynchronously, released on the clock
  logic rst_meta_n, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  logic [W-1:0] op0;
  assign op0 = opnd[W-1:0];

  bm_red_e red_kind;
  logic    red_inv;
  always_comb begin
    unique case (opcode)
      OP_OR, OP_NOR:   red_kind = RED_OR;
      OP_XOR, OP_XNOR: red_kind = RED_XOR;
      default:         red_kind = RED_AND;
    endcase
    red_inv = (opcode == OP_NAND) || (opcode == OP_NOR) || (opcode == OP_XNOR);
  end

  logic [W-1:0]    red_y, shf_y, tst_y, frc_y;
  logic [CNTW-1:0] pop_cnt;

  bm_reduce #(.W(W), .NOPS(NOPS)) u_reduce (
    .opnd(opnd), .en(opnd_en), .kind(red_kind), .invert(red_inv), .y(red_y)
  );

  bm_shift #(.W(W), .CW(CW)) u_shift (
    .a(op0), .amt(amt), .y(shf_y)
  );

  bm_popcount #(.W(W)) u_pop (
    .a(op0), .cnt(pop_cnt)
  );

  bm_bitfield #(.W(W), .CW(CW)) u_bits (
    .a(op0), .idx(amt), .val(bit_val), .test_y(tst_y), .force_y(frc_y)
  );

  // next-state
  logic [W-1:0] res_d;
  always_comb begin
    unique case (opcode)
      OP_INV:                         res_d = ~op0;
      OP_AND, OP_OR, OP_XOR,
      OP_NAND, OP_NOR, OP_XNOR:       res_d = red_y;
      OP_SHIFT:                       res_d = shf_y;
      OP_POPCNT:                      res_d = W'(pop_cnt);
      OP_TEST:                        res_d = tst_y;
      OP_FORCE:                       res_d = frc_y;
      default:                        res_d = '0;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result <= res_d;
      end
    end
  end
endmodule

// File: rtl/bm_unit_chk.sv
module bm_unit_chk #(
  parameter int W    = 64,
  parameter int NOPS = 4,
  parameter int CW   = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic [3:0]           opcode,
  input logic [NOPS*W-1:0]    opnd,
  input logic signed [CW-1:0] amt,
  input logic                 bit_val,
  input logic                 out_valid,
  input logic [W-1:0]         result
);
  localparam int IDXW = $clog2(W);

  logic idx_ok;
  assign idx_ok = (int'(amt) >= 0) && (int'(amt) < W);

  // R10
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R10
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R10
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result));

  // R7
  popcnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode == 4'd8) |=> (result <= W));

  // R8
  test_onebit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode == 4'd9) |=> (result[W-1:1] == '0));

  // R6
  big_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode == 4'd7 && (int'(amt) >= W || int'(amt) <= -W)) |=> (result == '0));

  // R9
  force_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode == 4'd10 && idx_ok) |=> (result[$past(amt[IDXW-1:0])] == $past(bit_val)));

  // R9
  force_oor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode == 4'd10 && !idx_ok) |=> (result == $past(opnd[W-1:0])));

  // R11
  undef_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode > 4'd10) |=> (result == '0));
endmodule

bind bitmanip_unit bm_unit_chk #(.W(W), .NOPS(NOPS), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
  .opnd(opnd), .amt(amt), .bit_val(bit_val),
  .out_valid(out_valid), .result(result)
);

// File: tb/sim_bitmanip_unit.sv
module sim_bitmanip_unit;
  logic              clk;
  logic              rst_n;
  logic              in_valid;
  logic [3:0]        opcode;
  logic [255:0]      opnd;
  logic [3:0]        opnd_en;
  logic signed [7:0] amt;
  logic              bit_val;
  logic              out_valid;
  logic [63:0]       result;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  bitmanip_unit u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
    .opnd(opnd), .opnd_en(opnd_en), .amt(amt), .bit_val(bit_val),
    .out_valid(out_valid), .result(result)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [63:0] model(logic [3:0] op, logic [255:0] ops,
                                        logic [3:0] en, logic signed [7:0] a,
                                        logic bv);
    logic [63:0] x;
    logic [63:0] acc;
    int n;
    x = ops[63:0];
    n = a;
    acc = '0;
    case (op)
      4'd0: return ~x;
      4'd1, 4'd4: begin
        acc = '1;
        for (int i = 0; i < 4; i++) if (en[i]) acc &= ops[i*64 +: 64];
        return (op == 4'd4) ? ~acc : acc;
      end
      4'd2, 4'd5: begin
        for (int i = 0; i < 4; i++) if (en[i]) acc |= ops[i*64 +: 64];
        return (op == 4'd5) ? ~acc : acc;
      end
      4'd3, 4'd6: begin
        for (int i = 0; i < 4; i++) if (en[i]) acc ^= ops[i*64 +: 64];
        return (op == 4'd6) ? ~acc : acc;
      end
      4'd7: begin
        if (n >= 64 || n <= -64) return '0;
        if (n >= 0) return x << n;
        return x >> (-n);
      end
      4'd8: return 64'($countones(x));
      4'd9: return (n >= 0 && n < 64) ? 64'(x[n]) : 64'd0;
      4'd10: begin
        if (n >= 0 && n < 64) x[n] = bv;
        return x;
      end
      default: return '0;
    endcase
  endfunction

  function automatic string op_tag(logic [3:0] op);
    if (op == 4'd0) return "R1";
    if (op <= 4'd3) return "R2";
    if (op <= 4'd6) return "R3";
    if (op == 4'd7) return "R5";
    if (op == 4'd8) return "R7";
    if (op == 4'd9) return "R8";
    if (op == 4'd10) return "R9";
    return "R11";
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_op(string tag, logic [3:0] op, logic [255:0] ops,
                        logic [3:0] en, logic signed [7:0] a, logic bv);
    logic [63:0] exp;
    string t;
    exp = model(op, ops, en, a, bv);
    t = (tag == "") ? op_tag(op) : tag;
    @(negedge clk);
    in_valid = 1'b1; opcode = op; opnd = ops; opnd_en = en; amt = a; bit_val = bv;
    @(negedge clk);
    in_valid = 1'b0;
    opnd = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
    check("R10 out_valid", 64'(out_valid), 64'd1);
    check(t, result, exp);
    // idle cycle: valid drops, result holds (R10)
    @(negedge clk);
    check("R10 idle valid", 64'(out_valid), 64'd0);
    check("R10 hold", result, exp);
  endtask

  function automatic logic [63:0] rnd_word();
    case ($urandom % 5)
      0: return '0;
      1: return '1;
      2: return 64'd1 << ($urandom % 64);
      default: return {$urandom, $urandom};
    endcase
  endfunction

  initial begin
    int unsigned seed;
    seed = $urandom(32'd20240611);
    rst_n = 1'b0; in_valid = 1'b0; opcode = '0; opnd = '0; opnd_en = '0;
    amt = '0; bit_val = 1'b0;
    repeat (3) @(negedge clk);
    check("R10 reset valid", 64'(out_valid), 64'd0);
    check("R10 reset result", result, 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R10 post-reset valid", 64'(out_valid), 64'd0);

    // directed corners
    run_op("R1", 4'd0, 256'd0, 4'h0, 8'sd0, 1'b0);
    run_op("R1", 4'd0, 256'd1, 4'h0, 8'sd0, 1'b0);
    run_op("R4 and-none", 4'd1, {4{64'h1234}}, 4'h0, 8'sd0, 1'b0);
    run_op("R4 or-none", 4'd2, {4{64'h1234}}, 4'h0, 8'sd0, 1'b0);
    run_op("R4 xor-none", 4'd3, {4{64'h1234}}, 4'h0, 8'sd0, 1'b0);
    run_op("R4 nand-none", 4'd4, {4{64'h1234}}, 4'h0, 8'sd0, 1'b0);
    run_op("R4 nor-none", 4'd5, {4{64'h1234}}, 4'h0, 8'sd0, 1'b0);
    run_op("R2 xor-two", 4'd3, {64'hF0, 64'hFF, 64'h0F, 64'h3C}, 4'b1010, 8'sd0, 1'b0);
    run_op("R3 xnor-all", 4'd6, {64'h1, 64'h2, 64'h4, 64'h8}, 4'hF, 8'sd0, 1'b0);
    run_op("R5 zero", 4'd7, {192'd0, 64'hDEAD_BEEF}, 4'h0, 8'sd0, 1'b0);
    run_op("R5 left63", 4'd7, {192'd0, 64'h3}, 4'h0, 8'sd63, 1'b0);
    run_op("R5 right63", 4'd7, {192'd0, 64'hC000_0000_0000_0000}, 4'h0, -8'sd63, 1'b0);
    run_op("R6 left64", 4'd7, {192'd0, 64'hFFFF}, 4'h0, 8'sd64, 1'b0);
    run_op("R6 right64", 4'd7, {192'd0, ~64'd0}, 4'h0, -8'sd64, 1'b0);
    run_op("R6 min", 4'd7, {192'd0, ~64'd0}, 4'h0, -8'sd128, 1'b0);
    run_op("R6 max", 4'd7, {192'd0, ~64'd0}, 4'h0, 8'sd127, 1'b0);
    run_op("R7 full", 4'd8, {192'd0, ~64'd0}, 4'h0, 8'sd0, 1'b0);
    run_op("R7 empty", 4'd8, {~192'd0, 64'd0}, 4'h0, 8'sd0, 1'b0);
    run_op("R8 top", 4'd9, {192'd0, 64'h8000_0000_0000_0000}, 4'h0, 8'sd63, 1'b0);
    run_op("R8 oor64", 4'd9, {192'd0, ~64'd0}, 4'h0, 8'sd64, 1'b0);
    run_op("R8 neg", 4'd9, {192'd0, ~64'd0}, 4'h0, -8'sd1, 1'b0);
    run_op("R9 set63", 4'd10, {192'd0, 64'h1}, 4'h0, 8'sd63, 1'b1);
    run_op("R9 clr0", 4'd10, {192'd0, ~64'd0}, 4'h0, 8'sd0, 1'b0);
    run_op("R9 oor", 4'd10, {192'd0, 64'h55AA}, 4'h0, -8'sd1, 1'b1);
    run_op("R9 oor64", 4'd10, {192'd0, 64'h55AA}, 4'h0, 8'sd64, 1'b0);
    run_op("R11", 4'd15, {4{~64'd0}}, 4'hF, 8'sd5, 1'b1);

    // constrained random
    for (int k = 0; k < 400; k++) begin
      logic [3:0] op;
      logic signed [7:0] a;
      op = ($urandom % 8 == 0) ? 4'($urandom % 16) : 4'($urandom % 11);
      a = ($urandom % 2 == 0) ? 8'($urandom % 64) : 8'($urandom);
      if (op == 4'd7 && $urandom % 2 == 0) a = -a;
      run_op("", op, {rnd_word(), rnd_word(), rnd_word(), rnd_word()},
             4'($urandom), a, 1'($urandom));
    end

    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule